// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block keeps the floating-point control and status state of one hart in a single clocked register. The state has two fields: five sticky exception flags and a three-bit rounding mode. Software reaches that state through three CSR addresses that share the storage. One address covers the flags alone, one covers the rounding mode alone, and one covers both packed into a byte. Each address has its own rule for merging a write into the state. A floating-point datapath next to the block ORs newly raised flags into the flag field. It also reads the live rounding mode from a dedicated output.

The CSR pipeline presents a request with an address, a write enable and write data. One cycle later the block returns a response. The response carries a valid strobe, an illegal indication and zero-extended read data. The three addresses exist only while floating point is usable. That means the F bit of misa is set and mstatus.FS is not Off, or the integer-register float mode input is high. Any other access is reported illegal and changes nothing. Every change to the state produces a one-cycle request to mark mstatus.FS Dirty. The mstatus and misa bits come in on input ports. The block does not store them.

Top module: `fp_csr_unit`

## Requirements
- R1: After reset both fields are zero, `frm_o` is 0, and no response, illegal indication or dirty request is active.
- R2: In the packed view at address 0x003, bits 7:5 are the rounding mode and bits 4:0 are the flags. Address 0x001 returns the flags in bits 4:0 and address 0x002 returns the rounding mode in bits 2:0. All higher read bits are zero. The response appears with `rsp_valid_o` high in the cycle after the request.
- R3: A write to 0x001 loads write-data bits 4:0 into the flags and leaves the rounding mode unchanged.
- R4: A write to 0x002 loads write-data bits 2:0 into the rounding mode and leaves the flags unchanged. All other write-data bits are ignored.
- R5: A write to 0x003 loads the rounding mode from bits 7:5 and the flags from bits 4:0. Bits above 7 have no effect.
- R6: `sp_en_o` is high exactly when misa F is 1 and mstatus.FS is not 2'b00. `dp_en_o` additionally needs misa D and a FLEN parameter of at least 64.
- R7: When `sp_en_o` is low and `finx_en_i` is low, an access to any of the three addresses responds with `rsp_illegal_o` = 1 and read data 0, and it leaves both fields unchanged.
- R8: The read data of any legal access is the selected field taken after that cycle's write and accrue have been applied.
- R9: When `acc_valid_i` is high, `acc_flags_i` is ORed into the flags. If a flag write happens in the same cycle, the written value is applied first and the accrued bits are ORed on top.
- R10: `fs_dirty_o` is high for exactly one cycle after each legal write and after each accrue with nonzero flags. Otherwise it is low.
- R11: A request to any other address gives no response and leaves the state untouched.
- R12: `frm_o` always shows the stored rounding mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| misa_f_i | input | 1 | misa single-precision bit |
| misa_d_i | input | 1 | misa double-precision bit |
| mstatus_fs_i | input | 2 | mstatus.FS field |
| finx_en_i | input | 1 | Floats-in-integer-registers mode enable |
| csr_req_i | input | 1 | CSR access request |
| csr_we_i | input | 1 | Request is a write |
| csr_addr_i | input | AW | CSR address |
| csr_wdata_i | input | XLEN | Write data |
| acc_valid_i | input | 1 | Flag accrue strobe from the FPU |
| acc_flags_i | input | 5 | Flags to accrue |
| rsp_valid_o | output | 1 | Response for one of the three addresses |
| rsp_illegal_o | output | 1 | Access was illegal |
| rsp_rdata_o | output | XLEN | Zero-extended response data |
| frm_o | output | 3 | Current rounding mode |
| fs_dirty_o | output | 1 | Request to set mstatus.FS to Dirty |
| sp_en_o | output | 1 | Single-precision enabled |
| dp_en_o | output | 1 | Double-precision enabled |

## Verification
A software write and an FPU accrue can land in the same cycle. Both then act on the flag field, and both can raise the dirty request. The bench drives these together on purpose. It writes flags through 0x001 and through 0x003 while accrue bits are pending. It also pairs a rounding-mode-only write with an accrue, and an illegal access with an accrue. Each response is judged against a reference model. The model applies the write first and ORs the accrued bits afterwards. The response data, the rounding mode output and the single dirty pulse must all agree with that order.

// File: rtl/fp_csr_unit.sv
module fp_csr_unit #(
  parameter int XLEN = 32,
  parameter int FLEN = 64,
  parameter int AW   = 12,
  parameter logic [AW-1:0] A_FLG = 12'h001,
  parameter logic [AW-1:0] A_RM  = 12'h002,
  parameter logic [AW-1:0] A_ALL = 12'h003
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            misa_f_i,
  input  logic            misa_d_i,
  input  logic [1:0]      mstatus_fs_i,
  input  logic            finx_en_i,
  input  logic            csr_req_i,
  input  logic            csr_we_i,
  input  logic [AW-1:0]   csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic            acc_valid_i,
  input  logic [4:0]      acc_flags_i,
  output logic            rsp_valid_o,
  output logic            rsp_illegal_o,
  output logic [XLEN-1:0] rsp_rdata_o,
  output logic [2:0]      frm_o,
  output logic            fs_dirty_o,
  output logic            sp_en_o,
  output logic            dp_en_o
);
  localparam int FW = 5;
  localparam int RW = 3;
  localparam logic DP_OK = (FLEN >= 64);

  logic [FW-1:0] flg_q, flg_mid, flg_nxt;
  logic [RW-1:0] rm_q, rm_nxt;
  logic sel_flg, sel_rm, sel_all, hit, legal, wr, acc_nz;
  logic [XLEN-1:0] rd_nxt;

  assign sp_en_o = misa_f_i & (mstatus_fs_i != 2'b00);
  assign dp_en_o = sp_en_o & misa_d_i & DP_OK;
  assign legal   = sp_en_o | finx_en_i;

  assign sel_flg = csr_addr_i == A_FLG;
  assign sel_rm  = csr_addr_i == A_RM;
  assign sel_all = csr_addr_i == A_ALL;
  assign hit     = csr_req_i & (sel_flg | sel_rm | sel_all);
  assign wr      = hit & legal & csr_we_i;
  assign acc_nz  = acc_valid_i & (|acc_flags_i);

  assign flg_mid = (wr & (sel_flg | sel_all)) ? csr_wdata_i[FW-1:0] : flg_q;
  assign flg_nxt = flg_mid | (acc_valid_i ? acc_flags_i : '0);

  always_comb begin
    rm_nxt = rm_q;
    if (wr & sel_rm)  rm_nxt = csr_wdata_i[RW-1:0];
    if (wr & sel_all) rm_nxt = csr_wdata_i[FW+RW-1:FW];
  end

  always_comb begin
    rd_nxt = '0;
    if (hit & legal) begin
      if (sel_flg)      rd_nxt[FW-1:0]      = flg_nxt;
      else if (sel_rm)  rd_nxt[RW-1:0]      = rm_nxt;
      else              rd_nxt[FW+RW-1:0]   = {rm_nxt, flg_nxt};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q         <= '0;
      rm_q          <= '0;
      rsp_valid_o   <= 1'b0;
      rsp_illegal_o <= 1'b0;
      rsp_rdata_o   <= '0;
      fs_dirty_o    <= 1'b0;
    end else begin
      flg_q         <= flg_nxt;
      rm_q          <= rm_nxt;
      rsp_valid_o   <= hit;
      rsp_illegal_o <= hit & ~legal;
      rsp_rdata_o   <= rd_nxt;
      fs_dirty_o    <= wr | acc_nz;
    end
  end

  assign frm_o = rm_q;

  // R3
  flg_write_keeps_rm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && csr_we_i && csr_addr_i == A_FLG) |=> $stable(frm_o));

  // R4
  rm_write_keeps_flg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && csr_we_i && csr_addr_i == A_RM && !acc_valid_i) |=> $stable(flg_q));

  // R7
  illegal_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && !sp_en_o && !finx_en_i && !acc_valid_i) |=> ($stable(flg_q) && $stable(frm_o)));

  // R7
  illegal_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal_o |-> (rsp_valid_o && rsp_rdata_o == '0));

  // R9
  accrue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i |=> ((flg_q & $past(acc_flags_i)) == $past(acc_flags_i)));

  // R10
  dirty_on_accrue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_flags_i != '0) |=> fs_dirty_o);

  // R6
  dp_needs_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_en_o |-> sp_en_o);
endmodule

// File: tb/fp_csr_unit_tb.sv
module fp_csr_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic misa_f_i = 1'b1, misa_d_i = 1'b1, finx_en_i = 1'b0;
  logic [1:0] mstatus_fs_i = 2'b01;
  logic csr_req_i = 1'b0, csr_we_i = 1'b0;
  logic [11:0] csr_addr_i = '0;
  logic [XLEN-1:0] csr_wdata_i = '0;
  logic acc_valid_i = 1'b0;
  logic [4:0] acc_flags_i = '0;
  logic rsp_valid_o, rsp_illegal_o, fs_dirty_o, sp_en_o, dp_en_o;
  logic [XLEN-1:0] rsp_rdata_o;
  logic [2:0] frm_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_csr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .misa_f_i(misa_f_i), .misa_d_i(misa_d_i),
    .mstatus_fs_i(mstatus_fs_i), .finx_en_i(finx_en_i), .csr_req_i(csr_req_i),
    .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i),
    .acc_valid_i(acc_valid_i), .acc_flags_i(acc_flags_i), .rsp_valid_o(rsp_valid_o),
    .rsp_illegal_o(rsp_illegal_o), .rsp_rdata_o(rsp_rdata_o), .frm_o(frm_o),
    .fs_dirty_o(fs_dirty_o), .sp_en_o(sp_en_o), .dp_en_o(dp_en_o));

  typedef struct {
    int unsigned cyc;
    logic vld, ill, dirty;
    logic [XLEN-1:0] rd;
    logic [2:0] rm;
    string tag;
  } item_t;

  item_t sbq[$];
  int unsigned cyc = 0;
  int n_chk = 0, n_fail = 0;
  logic [4:0] mf = '0;
  logic [2:0] mr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sbq.size() != 0 && sbq[0].cyc < cyc) begin
      item_t it;
      it = sbq.pop_front();
      chk({it.tag, " valid"}, XLEN'(rsp_valid_o), XLEN'(it.vld));
      if (it.vld) begin
        chk({it.tag, " illegal"}, XLEN'(rsp_illegal_o), XLEN'(it.ill));
        chk({it.tag, " rdata"}, rsp_rdata_o, it.rd);
      end
      chk({it.tag, " R10 dirty"}, XLEN'(fs_dirty_o), XLEN'(it.dirty));
      chk({it.tag, " R12 frm"}, XLEN'(frm_o), XLEN'(it.rm));
    end
  end

  task automatic op(input string tag, input logic req, input logic we, input logic [11:0] a,
                    input logic [XLEN-1:0] d, input logic av, input logic [4:0] af);
    item_t it;
    logic hit, legal, wr;
    @(negedge clk);
    csr_req_i = req; csr_we_i = we; csr_addr_i = a; csr_wdata_i = d;
    acc_valid_i = av; acc_flags_i = af;
    hit = req && (a == 12'h001 || a == 12'h002 || a == 12'h003);
    legal = (misa_f_i && mstatus_fs_i != 2'b00) || finx_en_i;
    wr = hit && legal && we;
    if (wr && (a == 12'h001 || a == 12'h003)) mf = d[4:0];
    if (wr && a == 12'h002) mr = d[2:0];
    if (wr && a == 12'h003) mr = d[7:5];
    if (av) mf = mf | af;
    it.cyc = cyc; it.vld = hit; it.ill = hit && !legal;
    it.dirty = wr || (av && af != 0);
    it.rm = mr; it.tag = tag;
    it.rd = '0;
    if (hit && legal) begin
      if (a == 12'h001) it.rd = XLEN'(mf);
      else if (a == 12'h002) it.rd = XLEN'(mr);
      else it.rd = XLEN'({mr, mf});
    end
    sbq.push_back(it);
    @(negedge clk);
    csr_req_i = 1'b0; csr_we_i = 1'b0; acc_valid_i = 1'b0; acc_flags_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 frm", XLEN'(frm_o), 0);
    chk("R1 valid", XLEN'(rsp_valid_o), 0);
    chk("R1 dirty", XLEN'(fs_dirty_o), 0);
    op("R1 read all", 1, 0, 12'h003, '0, 0, 0);
    // R6 enable decode
    #1 chk("R6 sp on", XLEN'(sp_en_o), 1);
    chk("R6 dp on", XLEN'(dp_en_o), 1);
    misa_d_i = 0; #1 chk("R6 dp needs D", XLEN'(dp_en_o), 0);
    misa_d_i = 1; mstatus_fs_i = 2'b00; #1 chk("R6 sp off FS", XLEN'(sp_en_o), 0);
    chk("R6 dp off FS", XLEN'(dp_en_o), 0);
    mstatus_fs_i = 2'b11; misa_f_i = 0; #1 chk("R6 sp off F", XLEN'(sp_en_o), 0);
    misa_f_i = 1; mstatus_fs_i = 2'b10;
    // R5 packed write, high bits ignored
    op("R5 write all", 1, 1, 12'h003, 32'hFFFF_FF6A, 0, 0);
    op("R2 R8 read all", 1, 0, 12'h003, '0, 0, 0);
    op("R2 read flags", 1, 0, 12'h001, '0, 0, 0);
    op("R2 read rm", 1, 0, 12'h002, '0, 0, 0);
    // R3 flags only
    op("R3 write flags", 1, 1, 12'h001, 32'hFFFF_FFF5, 0, 0);
    op("R3 check all", 1, 0, 12'h003, '0, 0, 0);
    // R4 rm only
    op("R4 write rm", 1, 1, 12'h002, 32'hABCD_EF01, 0, 0);
    op("R4 check all", 1, 0, 12'h003, '0, 0, 0);
    // R9 accrue alone and with writes
    op("R9 accrue only", 0, 0, 12'h000, '0, 1, 5'h0A);
    op("R9 accrue zero", 0, 0, 12'h000, '0, 1, 5'h00);
    op("R9 write flags plus accrue", 1, 1, 12'h001, 32'h0000_0001, 1, 5'h10);
    op("R9 write all plus accrue", 1, 1, 12'h003, 32'h0000_00E0, 1, 5'h04);
    op("R9 write rm plus accrue", 1, 1, 12'h002, 32'h0000_0003, 1, 5'h02);
    op("R8 read during accrue", 1, 0, 12'h001, '0, 1, 5'h08);
    // R11 unmapped address
    op("R11 write other", 1, 1, 12'h004, 32'hFF, 0, 0);
    op("R11 write zero addr", 1, 1, 12'h000, 32'hFF, 0, 0);
    op("R11 check all", 1, 0, 12'h003, '0, 0, 0);
    // R7 illegal when disabled
    mstatus_fs_i = 2'b00;
    op("R7 illegal write", 1, 1, 12'h003, 32'h0000_00FF, 0, 0);
    op("R7 illegal read", 1, 0, 12'h001, '0, 0, 0);
    op("R7 illegal with accrue", 1, 1, 12'h002, 32'h7, 1, 5'h01);
    // R7 finx mode keeps addresses defined
    finx_en_i = 1;
    op("R7 finx write", 1, 1, 12'h002, 32'h5, 0, 0);
    op("R7 finx read", 1, 0, 12'h003, '0, 0, 0);
    finx_en_i = 0; mstatus_fs_i = 2'b01;
    op("R2 final read", 1, 0, 12'h003, '0, 0, 0);
    op("R10 idle", 0, 0, 12'h000, '0, 0, 0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule